// File: doc/BRIEF.md
# Write-Back Disk Page Buffer

This block holds one 256-word page of a word-addressed disk in local storage and places it between a transfer engine that moves one 12-bit word at a time and a storage port that moves whole 512-byte blocks. The engine presents a 20-bit disk word address with a read or a write. If the held page matches, the access is served at once. Otherwise the buffer raises `busy`, writes the held page back if it was modified, fetches the page that was asked for, and then completes the original access.

The disk address splits into a 2-bit disk number, a 7-bit track number and an 11-bit word offset within a 2048-word track. Every 12-bit word takes one 16-bit slot of storage, so one page is exactly one block and a track fills eight blocks. The storage side is a command held until `block_done`, with one halfword moved per valid/ready beat in each direction.

Top module: `disk_page_wbuf`

## Requirements
- R1: The storage block number of an address is (address bits [19:11]) × 8 + address bits [10:8], 12 bits wide. The word index within the block is address bits [7:0], and halfword k of a block transfer carries index k, with k running 0 to 255.
- R2: While reset is asserted and after it is released, `busy`, `rsp_valid`, `block_rd`, `block_wr`, `fill_ready` and `flush_valid` are low. The held page tag is all ones and the page is clean, so the first access to any other page fetches without a write-back.
- R3: A read accepted while the page matches gives `rsp_valid` high with the stored word on `rsp_rdata` in the next cycle, and `busy` stays low.
- R4: A write accepted while the page matches replaces the stored word, marks the page modified, and gives `rsp_valid` in the next cycle with the written word on `rsp_rdata`.
- R5: On a miss with a clean page, the buffer asserts `block_rd` with the requested page's block number, stores bits [11:0] of each of the 256 halfwords it accepts and ignores bits [15:12], and after `block_done` performs the original access as a hit.
- R6: On a miss with a modified page, the buffer first asserts `block_wr` with the held page's block number and sends all 256 words with bits [15:12] zero, then fetches the requested page as in R5.
- R7: A write-back leaves the page clean: the next miss that follows only reads, with no write-back.
- R8: `busy` goes high in the cycle after a miss is accepted and stays high until the retried access. It falls in the same cycle that `rsp_valid` appears for that access.
- R9: `block_rd` or `block_wr` and `block_num` stay asserted and unchanged from the start of a command until `block_done`.
- R10: A request presented while `busy` is high is ignored: it produces no response and does not change any stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Word access request, taken when `busy` is low |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Disk word address {disk, track, word} |
| req_wdata | input | 12 | Word to write |
| busy | output | 1 | Miss handling in progress |
| rsp_valid | output | 1 | One-cycle completion pulse of an access |
| rsp_rdata | output | 12 | Word read, or word written |
| block_rd | output | 1 | Fetch a block from storage |
| block_wr | output | 1 | Write a block back to storage |
| block_num | output | 12 | Storage block number of the command |
| block_done | input | 1 | Storage command finished |
| fill_valid | input | 1 | Incoming halfword valid |
| fill_data | input | 16 | Incoming halfword |
| fill_ready | output | 1 | Buffer accepts an incoming halfword |
| flush_valid | output | 1 | Outgoing halfword valid |
| flush_data | output | 16 | Outgoing halfword |
| flush_ready | input | 1 | Storage accepts an outgoing halfword |

## Verification
The assertions assume that storage raises `block_done` only after all 256 halfwords of the command have moved, that it pulses `block_done` for a single cycle, and that it never raises it while no command is pending. The stubbed storage model in the bench completes each block in full before signalling done, inserts gaps in its own valid and ready signals, and drops done after one cycle. Stray requests during a miss are presented only while `busy` is observed high, so none of them can land on an idle cycle.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;

  typedef enum logic [1:0] {
    SB_IDLE  = 2'd0,
    SB_FLUSH = 2'd1,
    SB_FILL  = 2'd2,
    SB_RETRY = 2'd3
  } sb_state_e;

endpackage

// File: rtl/sbuf_rst_sync.sv
module sbuf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/sbuf_array.sv
module sbuf_array #(
  parameter int DATA_W = 12,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  acc_idx,
  output logic [DATA_W-1:0] acc_data,
  input  logic [IDX_W-1:0]  fl_idx,
  output logic [DATA_W-1:0] fl_data
);

  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  assign acc_data = mem[acc_idx];
  assign fl_data  = mem[fl_idx];

endmodule

// File: rtl/sbuf_tag.sv
module sbuf_tag #(
  parameter int TAG_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TAG_W-1:0] look_page,
  output logic             hit,
  input  logic             tag_load,
  input  logic [TAG_W-1:0] tag_new,
  input  logic             dirty_set,
  input  logic             dirty_clr,
  output logic [TAG_W-1:0] tag_q,
  output logic             dirty_q
);

  logic dirty_en;
  logic dirty_d;

  always_comb begin
    dirty_en = dirty_set | dirty_clr;
    dirty_d  = dirty_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q   <= '1;
      dirty_q <= 1'b0;
    end else begin
      if (tag_load) tag_q   <= tag_new;
      if (dirty_en) dirty_q <= dirty_d;
    end
  end

  assign hit = (tag_q == look_page);

  // a freshly loaded page must start clean
  AST_LOAD_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    tag_load |=> !dirty_q); // R7

endmodule

// File: rtl/sbuf_ctrl.sv
module sbuf_ctrl
  import sbuf_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int IDX_W  = 8,
  parameter int SUB_W  = 3,
  parameter int DATA_W = 12,
  parameter int HW_W   = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic                    req_write,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [DATA_W-1:0]       req_wdata,
  output logic                    busy,
  output logic                    rsp_valid,
  output logic [DATA_W-1:0]       rsp_rdata,
  output logic [ADDR_W-IDX_W-1:0] look_page,
  input  logic                    hit,
  input  logic [ADDR_W-IDX_W-1:0] tag_q,
  input  logic                    dirty_q,
  output logic                    tag_load,
  output logic [ADDR_W-IDX_W-1:0] tag_new,
  output logic                    dirty_set,
  output logic                    dirty_clr,
  output logic                    arr_wr_en,
  output logic [IDX_W-1:0]        arr_wr_idx,
  output logic [DATA_W-1:0]       arr_wr_data,
  output logic [IDX_W-1:0]        arr_acc_idx,
  input  logic [DATA_W-1:0]       arr_acc_data,
  output logic [IDX_W-1:0]        arr_fl_idx,
  input  logic [DATA_W-1:0]       arr_fl_data,
  output logic                    block_rd,
  output logic                    block_wr,
  output logic [ADDR_W-IDX_W-1:0] block_num,
  input  logic                    block_done,
  input  logic                    fill_valid,
  input  logic [HW_W-1:0]         fill_data,
  output logic                    fill_ready,
  output logic                    flush_valid,
  output logic [HW_W-1:0]         flush_data,
  input  logic                    flush_ready
);

  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int DT_W  = TAG_W - SUB_W;
  localparam int CNT_W = IDX_W + 1;
  localparam int PAD_W = HW_W - DATA_W;

  // block number = {disk,track} * 2^SUB_W + sub-page within the track
  function automatic logic [TAG_W-1:0] page2blk(input logic [TAG_W-1:0] pg);
    logic [TAG_W-1:0] base;
    logic [TAG_W-1:0] sub;
    base = {pg[TAG_W-1:SUB_W], {SUB_W{1'b0}}};
    sub  = {{DT_W{1'b0}}, pg[SUB_W-1:0]};
    return base + sub;
  endfunction

  // storage slot to word: upper pad bits carry nothing
  function automatic logic [DATA_W-1:0] slot2word(input logic [HW_W-1:0] hw);
    return hw[DATA_W-1:0];
  endfunction

  sb_state_e         state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              cnt_en;
  logic [ADDR_W-1:0] lat_addr_q;
  logic              lat_write_q;
  logic [DATA_W-1:0] lat_wdata_q;
  logic              rsp_valid_q;
  logic [DATA_W-1:0] rsp_rdata_q;

  logic              idle, in_retry, in_fill, in_flush;
  logic              accept, miss, access;
  logic              cur_write;
  logic [IDX_W-1:0]  cur_idx;
  logic [DATA_W-1:0] cur_wdata;
  logic              cnt_full, fill_beat, flush_beat;

  always_comb begin
    idle     = (state_q == SB_IDLE);
    in_retry = (state_q == SB_RETRY);
    in_fill  = (state_q == SB_FILL);
    in_flush = (state_q == SB_FLUSH);

    accept    = req_valid & idle;
    look_page = in_retry ? lat_addr_q[ADDR_W-1:IDX_W] : req_addr[ADDR_W-1:IDX_W];
    miss      = accept & ~hit;
    access    = (accept & hit) | in_retry;

    cur_write = in_retry ? lat_write_q : req_write;
    cur_idx   = in_retry ? lat_addr_q[IDX_W-1:0] : req_addr[IDX_W-1:0];
    cur_wdata = in_retry ? lat_wdata_q : req_wdata;

    cnt_full    = cnt_q[IDX_W];
    fill_ready  = in_fill & ~cnt_full;
    flush_valid = in_flush & ~cnt_full;
    fill_beat   = fill_ready & fill_valid;
    flush_beat  = flush_valid & flush_ready;
    flush_data  = {{PAD_W{1'b0}}, arr_fl_data};
    arr_fl_idx  = cnt_q[IDX_W-1:0];

    arr_wr_en   = fill_beat | (access & cur_write);
    arr_wr_idx  = fill_beat ? cnt_q[IDX_W-1:0] : cur_idx;
    arr_wr_data = fill_beat ? slot2word(fill_data) : cur_wdata;
    arr_acc_idx = cur_idx;

    dirty_set = access & cur_write;
    dirty_clr = (in_fill | in_flush) & block_done;
    tag_load  = in_fill & block_done;
    tag_new   = lat_addr_q[ADDR_W-1:IDX_W];

    block_rd  = in_fill;
    block_wr  = in_flush;
    block_num = in_flush ? page2blk(tag_q) : page2blk(lat_addr_q[ADDR_W-1:IDX_W]);

    busy      = ~idle;
    rsp_valid = rsp_valid_q;
    rsp_rdata = rsp_rdata_q;
  end

  // next state
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SB_IDLE:  if (miss) state_d = dirty_q ? SB_FLUSH : SB_FILL;
      SB_FLUSH: if (block_done) state_d = SB_FILL;
      SB_FILL:  if (block_done) state_d = SB_RETRY;
      SB_RETRY: state_d = SB_IDLE;
      default:  state_d = SB_IDLE;
    endcase
  end

  // beat counter
  always_comb begin
    cnt_en = 1'b1;
    cnt_d  = cnt_q;
    if (miss || (in_flush && block_done)) cnt_d = '0;
    else if (fill_beat || flush_beat)      cnt_d = cnt_q + 1'b1;
    else                                   cnt_en = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= SB_IDLE;
      cnt_q       <= '0;
      rsp_valid_q <= 1'b0;
    end else begin
      state_q     <= state_d;
      if (cnt_en) cnt_q <= cnt_d;
      rsp_valid_q <= access;
    end
  end

  always_ff @(posedge clk) begin
    if (miss) begin
      lat_addr_q  <= req_addr;
      lat_write_q <= req_write;
      lat_wdata_q <= req_wdata;
    end
    if (access) rsp_rdata_q <= cur_write ? cur_wdata : arr_acc_data;
  end

  AST_HIT_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    accept && hit |=> rsp_valid && !busy); // R3

  AST_MISS_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !hit |=> busy && !rsp_valid); // R8

  AST_BUSY_ENDS_WITH_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> rsp_valid); // R8

  AST_FLUSH_ONLY_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(block_wr) |-> dirty_q); // R6

  AST_RETRY_HITS: assert property (@(posedge clk) disable iff (!rst_n)
    in_retry |-> hit); // R5

  AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (block_rd || block_wr) && !block_done |=> (block_rd || block_wr) && $stable(block_num)); // R9

  AST_ONE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    !(fill_ready && flush_valid)); // R9

endmodule

// File: rtl/disk_page_wbuf.sv
module disk_page_wbuf #(
  parameter int DISK_BITS  = 2,
  parameter int TRACK_BITS = 7,
  parameter int WORD_BITS  = 11,
  parameter int IDX_BITS   = 8,
  parameter int DATA_W     = 12,
  parameter int HW_W       = 16
) (
  input  logic                                           clk,
  input  logic                                           rst_n,
  input  logic                                           req_valid,
  input  logic                                           req_write,
  input  logic [DISK_BITS+TRACK_BITS+WORD_BITS-1:0]      req_addr,
  input  logic [DATA_W-1:0]                              req_wdata,
  output logic                                           busy,
  output logic                                           rsp_valid,
  output logic [DATA_W-1:0]                              rsp_rdata,
  output logic                                           block_rd,
  output logic                                           block_wr,
  output logic [DISK_BITS+TRACK_BITS+WORD_BITS-IDX_BITS-1:0] block_num,
  input  logic                                           block_done,
  input  logic                                           fill_valid,
  input  logic [HW_W-1:0]                                fill_data,
  output logic                                           fill_ready,
  output logic                                           flush_valid,
  output logic [HW_W-1:0]                                flush_data,
  input  logic                                           flush_ready
);

  localparam int ADDR_W = DISK_BITS + TRACK_BITS + WORD_BITS;
  localparam int TAG_W  = ADDR_W - IDX_BITS;
  localparam int SUB_W  = WORD_BITS - IDX_BITS;

  logic              rst_n_s;
  logic [TAG_W-1:0]  look_page, tag_q, tag_new;
  logic              hit, dirty_q, tag_load, dirty_set, dirty_clr;
  logic              arr_wr_en;
  logic [IDX_BITS-1:0] arr_wr_idx, arr_acc_idx, arr_fl_idx;
  logic [DATA_W-1:0] arr_wr_data, arr_acc_data, arr_fl_data;

  sbuf_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  sbuf_tag #(.TAG_W(TAG_W)) u_tag (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .look_page (look_page),
    .hit       (hit),
    .tag_load  (tag_load),
    .tag_new   (tag_new),
    .dirty_set (dirty_set),
    .dirty_clr (dirty_clr),
    .tag_q     (tag_q),
    .dirty_q   (dirty_q)
  );

  sbuf_array #(.DATA_W(DATA_W), .IDX_W(IDX_BITS)) u_arr (
    .clk      (clk),
    .wr_en    (arr_wr_en),
    .wr_idx   (arr_wr_idx),
    .wr_data  (arr_wr_data),
    .acc_idx  (arr_acc_idx),
    .acc_data (arr_acc_data),
    .fl_idx   (arr_fl_idx),
    .fl_data  (arr_fl_data)
  );

  sbuf_ctrl #(
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_BITS),
    .SUB_W  (SUB_W),
    .DATA_W (DATA_W),
    .HW_W   (HW_W)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n_s),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .req_addr     (req_addr),
    .req_wdata    (req_wdata),
    .busy         (busy),
    .rsp_valid    (rsp_valid),
    .rsp_rdata    (rsp_rdata),
    .look_page    (look_page),
    .hit          (hit),
    .tag_q        (tag_q),
    .dirty_q      (dirty_q),
    .tag_load     (tag_load),
    .tag_new      (tag_new),
    .dirty_set    (dirty_set),
    .dirty_clr    (dirty_clr),
    .arr_wr_en    (arr_wr_en),
    .arr_wr_idx   (arr_wr_idx),
    .arr_wr_data  (arr_wr_data),
    .arr_acc_idx  (arr_acc_idx),
    .arr_acc_data (arr_acc_data),
    .arr_fl_idx   (arr_fl_idx),
    .arr_fl_data  (arr_fl_data),
    .block_rd     (block_rd),
    .block_wr     (block_wr),
    .block_num    (block_num),
    .block_done   (block_done),
    .fill_valid   (fill_valid),
    .fill_data    (fill_data),
    .fill_ready   (fill_ready),
    .flush_valid  (flush_valid),
    .flush_data   (flush_data),
    .flush_ready  (flush_ready)
  );

endmodule

// File: tb/test_disk_page_wbuf.sv
`timescale 1ns/1ps
module test_disk_page_wbuf;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [19:0] req_addr;
  logic [11:0] req_wdata;
  logic        busy, rsp_valid;
  logic [11:0] rsp_rdata;
  logic        block_rd, block_wr, block_done;
  logic [11:0] block_num;
  logic        fill_valid, fill_ready, flush_valid, flush_ready;
  logic [15:0] fill_data, flush_data;

  int n_total = 0;
  int n_fail  = 0;

  logic [11:0] ref_mem [int];
  logic [11:0] stor    [int];
  logic [11:0] exp_q   [$];
  string       exp_tag [$];
  bit          op_wr_q [$];
  logic [11:0] op_num_q[$];

  always #4 clk = ~clk;

  disk_page_wbuf i_disk_page_wbuf (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .busy(busy), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .block_rd(block_rd), .block_wr(block_wr), .block_num(block_num), .block_done(block_done),
    .fill_valid(fill_valid), .fill_data(fill_data), .fill_ready(fill_ready),
    .flush_valid(flush_valid), .flush_data(flush_data), .flush_ready(flush_ready)
  );

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [11:0] pat(input int a);
    return 12'((a * 37) ^ (a >> 7) ^ 'h2C3);
  endfunction

  // R1: block = addr[19:11]*8 + addr[10:8]
  function automatic logic [11:0] blk_of(input logic [19:0] a);
    return 12'(int'(a[19:11]) * 8 + int'(a[10:8]));
  endfunction

  function automatic logic [11:0] ref_word(input logic [19:0] a);
    if (ref_mem.exists(int'(a))) return ref_mem[int'(a)];
    return pat(int'(a));
  endfunction

  function automatic logic [11:0] stor_word(input logic [11:0] num, input int k);
    int key = int'(num) * 256 + k;
    if (stor.exists(key)) return stor[key];
    return pat(key);
  endfunction

  // driver: called at a negedge, returns at the negedge after acceptance
  task automatic do_req(input bit wr, input logic [19:0] a, input logic [11:0] d, input string tag);
    while (busy) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    exp_q.push_back(wr ? d : ref_word(a));
    exp_tag.push_back(tag);
    if (wr) ref_mem[int'(a)] = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy || exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic push_op(input bit wr, input logic [19:0] a);
    op_wr_q.push_back(wr);
    op_num_q.push_back(blk_of(a));
  endtask

  // monitor: scoreboard pop/compare
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R10", "unexpected response", int'(rsp_rdata), 0);
      end else begin
        logic [11:0] e;
        string t;
        e = exp_q.pop_front();
        t = exp_tag.pop_front();
        check(rsp_rdata == e, t, "response data", int'(rsp_rdata), int'(e));
        check(!busy, "R8", "busy low at response", int'(busy), 0);
      end
    end
  end

  // storage responder
  initial begin
    bit          is_wr, held_ok, hi_ok, rdy, v;
    logic [11:0] num;
    logic [15:0] d;
    int          beats, cyc;
    block_done = 1'b0; fill_valid = 1'b0; fill_data = '0; flush_ready = 1'b0;
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      if (block_rd || block_wr) begin
        is_wr = block_wr; num = block_num; held_ok = 1'b1; hi_ok = 1'b1;
        beats = 0; cyc = 0;
        if (op_wr_q.size() == 0) begin
          check(1'b0, "R7", "unexpected storage command", int'(is_wr), 0);
        end else begin
          bit          ew;
          logic [11:0] en;
          ew = op_wr_q.pop_front();
          en = op_num_q.pop_front();
          check(is_wr == ew, is_wr ? "R6" : "R5", "command kind", int'(is_wr), int'(ew));
          check(num == en, "R1", "block number", int'(num), int'(en));
        end
        if (!is_wr) begin
          while (beats < 256) begin
            fill_valid = (cyc % 50) != 49;
            fill_data  = {4'hA, stor_word(num, beats)};
            rdy = fill_ready;
            @(negedge clk); cyc++;
            if (fill_valid && rdy) beats++;
            if (!block_rd || block_num != num) held_ok = 1'b0;
          end
          fill_valid = 1'b0;
        end else begin
          while (beats < 256) begin
            flush_ready = (cyc % 3) != 2;
            v = flush_valid; d = flush_data;
            @(negedge clk); cyc++;
            if (v && flush_ready) begin
              if (d[15:12] != 4'h0) hi_ok = 1'b0;
              stor[int'(num) * 256 + beats] = d[11:0];
              beats++;
            end
            if (!block_wr || block_num != num) held_ok = 1'b0;
          end
          flush_ready = 1'b0;
          check(hi_ok, "R6", "flushed pad bits zero", int'(hi_ok), 1);
        end
        block_done = 1'b1;
        @(negedge clk);
        block_done = 1'b0;
        check(held_ok, "R9", "command held until done", int'(held_ok), 1);
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_total++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  localparam logic [19:0] A = 20'h12345;
  localparam logic [19:0] B = 20'h80A10;
  localparam logic [19:0] C = 20'hC1F00;
  localparam logic [19:0] D = 20'hFF7AB;
  localparam logic [19:0] E = 20'h00010;

  initial begin
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(!busy && !rsp_valid && !block_rd && !block_wr && !fill_ready && !flush_valid,
          "R2", "outputs in reset", int'({busy, rsp_valid, block_rd, block_wr}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!busy && !block_rd && !block_wr, "R2", "outputs after reset", int'({busy, block_rd, block_wr}), 0);

    // R2/R5: first access fetches without write-back
    push_op(1'b0, A);
    do_req(1'b0, A, '0, "R5");
    check(busy && !rsp_valid, "R8", "busy after miss", int'(busy), 1);
    wait_idle();

    do_req(1'b0, A + 20'd1, '0, "R3");
    check(rsp_valid && !busy, "R3", "read hit next cycle", int'(rsp_valid), 1);
    do_req(1'b1, A + 20'd2, 12'h5A5, "R4");
    check(rsp_valid && !busy, "R4", "write hit next cycle", int'(rsp_valid), 1);
    do_req(1'b0, A + 20'd2, '0, "R4");
    do_req(1'b1, {A[19:8], 8'hFF}, 12'h0F0, "R4");
    do_req(1'b0, {A[19:8], 8'h00}, '0, "R1");
    wait_idle();

    // R6: dirty miss, with stray writes while busy (R10)
    push_op(1'b1, A);
    push_op(1'b0, B);
    do_req(1'b0, B, '0, "R6");
    check(busy && !rsp_valid, "R8", "busy after dirty miss", int'(busy), 1);
    for (int k = 0; k < 20; k++) begin
      if (!busy) break;
      req_valid = 1'b1; req_write = 1'b1; req_addr = A + 20'd3; req_wdata = 12'hBAD;
      @(negedge clk);
      req_valid = 1'b0;
    end
    req_valid = 1'b0;
    wait_idle();
    do_req(1'b0, B + 20'd1, '0, "R3");
    wait_idle();

    // R7: clean miss after write-back reads only
    push_op(1'b0, C);
    do_req(1'b0, C, '0, "R7");
    wait_idle();

    // R6/R10: flushed data came back, stray write had no effect
    push_op(1'b0, A);
    do_req(1'b0, A + 20'd2, '0, "R6");
    do_req(1'b0, A + 20'd3, '0, "R10");
    do_req(1'b0, {A[19:8], 8'hFF}, '0, "R6");
    wait_idle();

    // high disk/track bits, write miss then write-back
    push_op(1'b0, D);
    do_req(1'b1, D, 12'h3C3, "R5");
    wait_idle();
    do_req(1'b0, D, '0, "R4");
    wait_idle();
    push_op(1'b1, D);
    push_op(1'b0, E);
    do_req(1'b0, E, '0, "R6");
    wait_idle();
    push_op(1'b0, D);
    do_req(1'b0, D, '0, "R6");
    wait_idle();

    repeat (5) @(negedge clk);
    check(op_wr_q.size() == 0, "R5", "all storage commands issued", op_wr_q.size(), 0);
    check(exp_q.size() == 0, "R8", "all responses seen", exp_q.size(), 0);
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

endmodule